// File: doc/BRIEF.md
# Configuration Window Base Register Decoder

This block holds the 64-bit base register that places the memory-mapped PCIe configuration window, and turns its contents into registered decode outputs. Software writes the register as two 32-bit dwords through a byte-addressed write port with per-byte enables, and can read it back. From the stored value the block derives whether the window is on, the window base address and its size. It also derives the lower and upper bounds of the 32-bit PCI memory hole that sits just above the window.

The size field selects one of three window sizes. A smaller window permits a finer base alignment, so more low address bits of the base survive the mask as the window shrinks. The fourth size code is illegal. Writing it stores the value but keeps the previous decode, and raises an error flag that stays set until reset. When the window is off, the hole starts at the reset base instead of at the window end.

Top module: `cfgbar_decoder`

## Requirements
- R1: After reset the register reads 0x00000000_B0000000 (low dword at byte offset 0x60, high dword at 0x64). The window is off, the base is 0xB0000000, the size is 256 MiB, the hole lower bound is 0xB0000000 and the error flag is clear.
- R2: A write whose dword address is 0x60 or 0x64 changes only the register bytes whose byte enable is set. Byte lane k of `wdata` lands in byte k of that dword.
- R3: With `rd_en` high, `rdata` shows the addressed register dword after the next clock edge, as it stood before any write on that same edge. Any other address returns zero. Without `rd_en`, `rdata` holds its value.
- R4: Register bit 0 is the window enable and drives `win_en`.
- R5: Register bits [2:1] select the size: 00 gives 256 MiB, 01 gives 128 MiB, 10 gives 64 MiB. `win_len` carries the size in bytes.
- R6: `win_base` always keeps register bits [35:28]. It adds bit 27 for 128 MiB and bits [27:26] for 64 MiB. All other bits read zero, and register bits above 35 are ignored.
- R7: While the window is on, the hole lower bound equals base plus size. The hole upper bound is always 0xFEBFFFFF.
- R8: While the window is off, the hole lower bound is 0xB0000000, whatever the stored base.
- R9: A write that leaves size code 11 in the register sets `len_err`, which stays set until reset. The decode outputs keep their previous values. A later legal write still updates the decode.
- R10: A write to any other address, or with all byte enables clear, changes neither the register nor the decode outputs.
- R11: The decode outputs take their new values on the same clock edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| wbe | input | 4 | Byte enables for wdata |
| rdata | output | 32 | Registered read data |
| win_en | output | 1 | Window enabled |
| win_base | output | PHYS_W | Masked window base address |
| win_len | output | PHYS_W | Window size in bytes |
| hole_lo | output | PHYS_W+1 | PCI hole lower bound |
| hole_hi | output | PHYS_W+1 | PCI hole upper bound (inclusive) |
| len_err | output | 1 | Sticky illegal-size flag |

## Verification
The hardest case to reach is the reserved size code arriving while a good decode is already in place. The flag must rise, the decode must stay frozen, and a later legal write must then change the decode while the flag stays up. The stimulus first builds a distinctive decode, with the window off and a base above 4 GiB. It then writes code 11 through a single-byte write, so the readback can confirm the byte landed. Finally it writes a legal value. The byte-enable cases are reached the same way: partial writes to each dword, each followed by a readback.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;
  typedef enum logic [1:0] {
    WSZ_256M = 2'b00,
    WSZ_128M = 2'b01,
    WSZ_64M  = 2'b10,
    WSZ_RSVD = 2'b11
  } win_size_e;

  localparam int ENABLE_BIT = 0;
  localparam int SIZE_LSB   = 1;
  localparam int SHIFT_256M = 28;
  localparam int SHIFT_128M = 27;
  localparam int SHIFT_64M  = 26;
  localparam int REG_BYTES  = 8;
endpackage

// File: rtl/cfgbar_wr_merge.sv
module cfgbar_wr_merge #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h60
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wbe,
  input  logic [63:0]       cur,
  output logic              hit,
  output logic [63:0]       nxt
);
  import cfgbar_pkg::*;

  localparam logic [ADDR_W-3:0] LO_IDX = REG_OFS[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] HI_IDX = LO_IDX + 1'b1;

  logic [1:0] dw_sel;

  always_comb begin
    dw_sel[0] = wr_en && (addr[ADDR_W-1:2] == LO_IDX);
    dw_sel[1] = wr_en && (addr[ADDR_W-1:2] == HI_IDX);
  end

  assign hit = (|dw_sel) && (|wbe);

  for (genvar i = 0; i < REG_BYTES; i++) begin : g_byte
    localparam int DW   = i / 4;
    localparam int LANE = i % 4;
    assign nxt[i*8 +: 8] = (dw_sel[DW] && wbe[LANE]) ? wdata[LANE*8 +: 8]
                                                     : cur[i*8 +: 8];
  end
endmodule

// File: rtl/cfgbar_win_decode.sv
module cfgbar_win_decode #(
  parameter int PHYS_W = 36
) (
  input  logic [63:0]       reg_val,
  output logic              en,
  output logic [PHYS_W-1:0] base,
  output logic [PHYS_W-1:0] len,
  output logic              rsvd
);
  import cfgbar_pkg::*;

  win_size_e   code;
  logic        keep27;
  logic        keep26;

  always_comb begin
    code   = win_size_e'(reg_val[SIZE_LSB +: 2]);
    en     = reg_val[ENABLE_BIT];
    rsvd   = (code == WSZ_RSVD);
    keep27 = (code == WSZ_128M) || (code == WSZ_64M);
    keep26 = (code == WSZ_64M);
  end

  for (genvar i = 0; i < PHYS_W; i++) begin : g_bit
    if (i >= SHIFT_256M) begin : g_hi
      assign base[i] = reg_val[i];
      assign len[i]  = (i == SHIFT_256M) && (code == WSZ_256M);
    end else if (i == SHIFT_128M) begin : g_27
      assign base[i] = reg_val[i] & keep27;
      assign len[i]  = (code == WSZ_128M);
    end else if (i == SHIFT_64M) begin : g_26
      assign base[i] = reg_val[i] & keep26;
      assign len[i]  = (code == WSZ_64M);
    end else begin : g_lo
      assign base[i] = 1'b0;
      assign len[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/cfgbar_hole_calc.sv
module cfgbar_hole_calc #(
  parameter int PHYS_W = 36,
  parameter logic [63:0] DEF_BASE = 64'hB000_0000
) (
  input  logic              en,
  input  logic [PHYS_W-1:0] base,
  input  logic [PHYS_W-1:0] len,
  output logic [PHYS_W:0]   lo
);
  localparam logic [PHYS_W:0] FALLBACK = DEF_BASE[PHYS_W:0];

  always_comb begin
    if (en) lo = {1'b0, base} + {1'b0, len};
    else    lo = FALLBACK;
  end
endmodule

// File: rtl/cfgbar_decoder.sv
module cfgbar_decoder #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h60,
  parameter int PHYS_W = 36,
  parameter logic [63:0] DEF_BASE = 64'hB000_0000,
  parameter logic [63:0] HOLE_LIMIT = 64'hFEC0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wbe,
  output logic [31:0]       rdata,
  output logic              win_en,
  output logic [PHYS_W-1:0] win_base,
  output logic [PHYS_W-1:0] win_len,
  output logic [PHYS_W:0]   hole_lo,
  output logic [PHYS_W:0]   hole_hi,
  output logic              len_err
);
  import cfgbar_pkg::*;

  localparam logic [ADDR_W-3:0] LO_IDX   = REG_OFS[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] HI_IDX   = LO_IDX + 1'b1;
  localparam logic [PHYS_W-1:0] RST_LEN  = PHYS_W'(1) << SHIFT_256M;
  localparam logic [PHYS_W-1:0] RST_BASE = DEF_BASE[PHYS_W-1:0] & ~(RST_LEN - 1'b1);
  localparam logic [PHYS_W:0]   LIMIT_M1 = HOLE_LIMIT[PHYS_W:0] - 1'b1;

  logic [63:0]       reg_q;
  logic [63:0]       reg_nxt;
  logic              wr_hit;
  logic              d_en;
  logic [PHYS_W-1:0] d_base;
  logic [PHYS_W-1:0] d_len;
  logic              d_rsvd;
  logic [PHYS_W:0]   d_hole;

  cfgbar_wr_merge #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_merge (
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .wbe(wbe),
    .cur(reg_q), .hit(wr_hit), .nxt(reg_nxt)
  );

  cfgbar_win_decode #(.PHYS_W(PHYS_W)) u_dec (
    .reg_val(reg_nxt), .en(d_en), .base(d_base), .len(d_len), .rsvd(d_rsvd)
  );

  cfgbar_hole_calc #(.PHYS_W(PHYS_W), .DEF_BASE(DEF_BASE)) u_hole (
    .en(d_en), .base(d_base), .len(d_len), .lo(d_hole)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= DEF_BASE;
      win_en   <= 1'b0;
      win_base <= RST_BASE;
      win_len  <= RST_LEN;
      hole_lo  <= DEF_BASE[PHYS_W:0];
      len_err  <= 1'b0;
    end else if (wr_hit) begin
      reg_q <= reg_nxt;
      if (d_rsvd) begin
        len_err <= 1'b1;
      end else begin
        win_en   <= d_en;
        win_base <= d_base;
        win_len  <= d_len;
        hole_lo  <= d_hole;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr[ADDR_W-1:2] == LO_IDX)      rdata <= reg_q[31:0];
      else if (addr[ADDR_W-1:2] == HI_IDX) rdata <= reg_q[63:32];
      else                                 rdata <= '0;
    end
  end

  assign hole_hi = LIMIT_M1;
endmodule

// File: rtl/cfgbar_decoder_chk.sv
module cfgbar_decoder_chk #(
  parameter int PHYS_W = 36,
  parameter logic [63:0] DEF_BASE = 64'hB000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              win_en,
  input logic [PHYS_W-1:0] win_base,
  input logic [PHYS_W-1:0] win_len,
  input logic [PHYS_W:0]   hole_lo,
  input logic              len_err
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    len_err |=> len_err); // R9

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(len_err) |-> $past(wr_en)); // R9

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ($countones(win_len) == 1) && (win_len[28] || win_len[27] || win_len[26])); // R5

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (win_base & (win_len - 1'b1)) == '0); // R6

  AST_HOLE_AFTER_WIN: assert property (@(posedge clk) disable iff (rst)
    win_en |-> (hole_lo == ({1'b0, win_base} + {1'b0, win_len}))); // R7

  AST_HOLE_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    !win_en |-> (hole_lo == DEF_BASE[PHYS_W:0])); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(win_en) && $stable(win_base) && $stable(win_len))); // R10
endmodule

bind cfgbar_decoder cfgbar_decoder_chk #(.PHYS_W(PHYS_W), .DEF_BASE(DEF_BASE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .win_en(win_en), .win_base(win_base),
  .win_len(win_len), .hole_lo(hole_lo), .len_err(len_err)
);

// File: tb/tb_cfgbar_decoder.sv
module tb_cfgbar_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wbe = '0;
  logic [31:0] rdata;
  logic        win_en;
  logic [35:0] win_base;
  logic [35:0] win_len;
  logic [36:0] hole_lo;
  logic [36:0] hole_hi;
  logic        len_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  cfgbar_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wbe(wbe), .rdata(rdata), .win_en(win_en),
    .win_base(win_base), .win_len(win_len), .hole_lo(hole_lo),
    .hole_hi(hole_hi), .len_err(len_err)
  );

  always #2 clk = ~clk;

  // behavioural reference state
  logic [63:0] m_reg;
  logic        m_en;
  logic [35:0] m_base;
  logic [35:0] m_len;
  logic [36:0] m_hole;
  logic        m_err;
  logic [31:0] m_rd;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int sh;
    if (rst) begin
      m_reg = 64'hB000_0000; m_en = 0; m_base = 36'hB000_0000;
      m_len = 36'h1000_0000; m_hole = 37'hB000_0000; m_err = 0; m_rd = 0;
      return;
    end
    if (rd_en) begin
      if (addr[7:2] == 6'h18)      m_rd = m_reg[31:0];
      else if (addr[7:2] == 6'h19) m_rd = m_reg[63:32];
      else                         m_rd = 0;
    end
    if (wr_en && wbe != 0 && (addr[7:2] == 6'h18 || addr[7:2] == 6'h19)) begin
      for (int k = 0; k < 4; k++)
        if (wbe[k]) m_reg[(addr[2] ? 32 : 0) + k*8 +: 8] = wdata[k*8 +: 8];
      if (m_reg[2:1] == 2'b11) begin
        m_err = 1;
      end else begin
        sh = 28 - int'(m_reg[2:1]);
        m_en = m_reg[0];
        m_len = 36'd1 << sh;
        m_base = (m_reg[35:0] >> sh) << sh;
        m_hole = m_en ? ({1'b0, m_base} + {1'b0, m_len}) : 37'hB000_0000;
      end
    end
  endtask

  // R11: every output follows the model on every cycle
  task automatic compare_all();
    chk("R11 en", 64'(win_en), 64'(m_en));
    chk("R11 base", 64'(win_base), 64'(m_base));
    chk("R11 len", 64'(win_len), 64'(m_len));
    chk("R11 hole_lo", 64'(hole_lo), 64'(m_hole));
    chk("R11 err", 64'(len_err), 64'(m_err));
    chk("R11 rdata", 64'(rdata), 64'(m_rd));
    chk("R7 hole_hi", 64'(hole_hi), 64'hFEBF_FFFF);
  endtask

  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic [3:0] b);
    wr_en = w; rd_en = r; addr = a; wdata = d; wbe = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    step(1'b1, 1'b0, a, d, b);
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b0, 1'b1, a, 32'h0, 4'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 1'b0, 8'h0, 32'h0, 4'h0);
    step(1'b0, 1'b0, 8'h0, 32'h0, 4'h0);
    rst = 1'b0;
  endtask

  task automatic check_reset_state();
    chk("R1 en", 64'(win_en), 64'h0);
    chk("R1 base", 64'(win_base), 64'hB000_0000);
    chk("R1 len", 64'(win_len), 64'h1000_0000);
    chk("R1 hole_lo", 64'(hole_lo), 64'hB000_0000);
    chk("R1 err", 64'(len_err), 64'h0);
    rd(8'h60); chk("R1 read lo", 64'(rdata), 64'hB000_0000);
    rd(8'h64); chk("R1 read hi", 64'(rdata), 64'h0);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check_reset_state();

    wr(8'h60, 32'hE000_0001, 4'hF);
    chk("R4 enable", 64'(win_en), 64'h1);
    chk("R7 hole on", 64'(hole_lo), 64'hF000_0000);

    wr(8'h60, 32'hC800_0003, 4'hF);
    chk("R5 128M", 64'(win_len), 64'h0800_0000);
    chk("R6 bit27 kept", 64'(win_base), 64'hC800_0000);
    chk("R7 hole 128M", 64'(hole_lo), 64'hD000_0000);

    wr(8'h60, 32'hC7FF_FFF5, 4'hF);
    chk("R5 64M", 64'(win_len), 64'h0400_0000);
    chk("R6 bits27:26", 64'(win_base), 64'hC400_0000);
    chk("R7 hole 64M", 64'(hole_lo), 64'hC800_0000);

    wr(8'h60, 32'hC7FF_FFF1, 4'hF);
    chk("R5 256M", 64'(win_len), 64'h1000_0000);
    chk("R6 256M mask", 64'(win_base), 64'hC000_0000);

    wr(8'h64, 32'hFFFF_FFF3, 4'h1);
    chk("R6 upper base", 64'(win_base), 64'h3_C000_0000);
    chk("R7 hole above 4G", 64'(hole_lo), 64'h3_D000_0000);
    rd(8'h64); chk("R2 hi byte lane", 64'(rdata), 64'h0000_00F3);

    wr(8'h60, 32'h0000_0000, 4'h1);
    chk("R4 disable", 64'(win_en), 64'h0);
    chk("R8 fallback", 64'(hole_lo), 64'hB000_0000);
    rd(8'h60); chk("R2 lo byte0 only", 64'(rdata), 64'hC7FF_FF00);

    wr(8'h10, 32'h0000_0007, 4'hF);
    wr(8'h60, 32'h0000_0007, 4'h0);
    chk("R10 no change base", 64'(win_base), 64'h3_C000_0000);
    chk("R10 no change err", 64'(len_err), 64'h0);
    rd(8'h60); chk("R10 reg untouched", 64'(rdata), 64'hC7FF_FF00);
    rd(8'h10); chk("R3 other addr", 64'(rdata), 64'h0);

    wr(8'h60, 32'h0000_0007, 4'h1);
    chk("R9 err set", 64'(len_err), 64'h1);
    chk("R9 decode held en", 64'(win_en), 64'h0);
    chk("R9 decode held base", 64'(win_base), 64'h3_C000_0000);
    rd(8'h60); chk("R3 stored rsvd", 64'(rdata), 64'hC7FF_FF07);

    step(1'b1, 1'b1, 8'h60, 32'hE000_0001, 4'hF);
    chk("R3 read before write", 64'(rdata), 64'hC7FF_FF07);
    chk("R9 later write decodes", 64'(win_base), 64'h3_E000_0000);
    chk("R9 err sticky", 64'(len_err), 64'h1);
    chk("R7 hole", 64'(hole_lo), 64'h3_F000_0000);

    wr(8'h64, 32'h0, 4'hF);
    chk("R6 upper cleared", 64'(win_base), 64'hE000_0000);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'h60, 32'hFFFF_FFFF, 4'hF);
    chk("R10 idle hold", 64'(win_base), 64'hE000_0000);

    do_reset();
    check_reset_state();

    finished = 1;
    report();
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end
endmodule